// File: doc/BRIEF.md
# Reverse-channel byte receiver for an interlocked parallel port (host side)

This block sits on the host side of a parallel port that runs in the reverse direction, with the peripheral sending and the host receiving. The peripheral announces each byte by pulling its strobe line low. The host answers on a single acknowledge line. A low level on that line tells the peripheral that the host can take a byte. A rising edge tells it that the byte has been taken. The line falls again once the byte has left the host, which closes the transfer.

The strobe arrives from off chip, so it passes through a synchronizer. The data bus is registered on every cycle. Each captured byte goes out on a valid/ready stream. The output holds a single byte. While that byte waits for the consumer, the acknowledge line stays high, and this stalls the peripheral. Back-pressure from downstream therefore slows the cable handshake directly, and no byte is ever dropped. The stream follows the usual rules: a byte moves on a cycle where valid and ready are both high. Once valid is up, the byte and valid stay fixed until that cycle. The consumer may hold ready low for as long as it likes.

An enable input turns the engine off. If the peripheral leaves its strobe low for too long after the acknowledge rises, a timeout flag is raised.

Top module: `ecp_rev_host`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `host_ack_o`, `m_valid_o` and `timeout_err_o` are all 0.
- R2: While `enable_i` is 0, `host_ack_o` is 0 one cycle later and no new byte is captured, even if the strobe is held low. The engine picks up a strobe that is still low once it is enabled again.
- R3: `host_ack_o` rises only after the synchronized strobe has been seen low. With SYNC_STAGES=2, and with the engine enabled and empty, it rises on the third clock edge after `periph_clk_n_i` falls.
- R4: The byte placed on `m_data_o` is the value on `bus_data_i` while the strobe is low (0). `m_valid_o` rises on the same edge as `host_ack_o`.
- R5: Once `host_ack_o` is high, it stays high for as long as the synchronized strobe stays low.
- R6: `host_ack_o` returns to 0 only when the output holds no byte, or when its byte is accepted on that same edge. A strobe that is already high does not end the handshake on its own.
- R7: While `m_valid_o` is 1 and `m_ready_i` is 0, `m_valid_o` stays 1 and `m_data_o` does not change.
- R8: Each handshake delivers exactly one byte. Bytes leave in the order the peripheral sent them, with none lost and none repeated.
- R9: If the strobe is still low TIMEOUT_CYC cycles after `host_ack_o` rises, `timeout_err_o` goes to 1. It rises exactly TIMEOUT_CYC cycles after the acknowledge edge, `host_ack_o` stays 1 while the flag is set, and both clear one cycle after `enable_i` goes to 0.
- R10: When the engine is enabled and idle, with the strobe high and the output empty, `host_ack_o` rests at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Engine enable; when 0 the acknowledge line is held low |
| periph_clk_n_i | input | 1 | Peripheral strobe, active low, asynchronous |
| bus_data_i | input | DATA_W | Parallel data bus driven by the peripheral |
| host_ack_o | output | 1 | Host acknowledge line to the peripheral |
| timeout_err_o | output | 1 | Strobe failed to return high in time |
| m_valid_o | output | 1 | Output stream valid |
| m_data_o | output | DATA_W | Output stream byte |
| m_ready_i | input | 1 | Output stream ready from the consumer |

## Verification
The bench builds the block with DATA_W=8 and SYNC_STAGES=2, so the acknowledge latency after a strobe fall is a known three edges. It sets TIMEOUT_CYC to 24 rather than the large default. With that value a stuck strobe reaches the error state within a few dozen cycles, so the exact cycle the flag rises can be measured. It also keeps a normal hold time of up to nine cycles well clear of the limit. Random strobe setup and hold times, combined with random consumer stalls, drive the acknowledge line through every one of its waiting states.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;

  // Host-side handshake states for the reverse channel
  typedef enum logic [1:0] {
    ST_READY = 2'd0,  // ack low, waiting for the strobe to fall
    ST_ACK   = 2'd1,  // ack high, waiting for the strobe to return high
    ST_DRAIN = 2'd2,  // ack high, waiting for the output byte to leave
    ST_FAULT = 2'd3   // ack high, strobe stuck low past the limit
  } rev_state_e;

endpackage

// File: rtl/ecp_rev_sync.sv
module ecp_rev_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RESET_VAL}};
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ecp_rev_outbuf.sv
module ecp_rev_outbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              load_i,
  input  logic              m_ready_i,
  output logic              m_valid_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              full_o,
  output logic              pop_o
);

  logic [DATA_W-1:0] bus_q;
  logic [DATA_W-1:0] hold_q;
  logic              valid_q;

  // Input register: samples the cable bus on every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_q <= '0;
    else        bus_q <= bus_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hold_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      hold_q  <= bus_q;
    end else if (valid_q && m_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign m_valid_o = valid_q;
  assign m_data_o  = hold_q;
  assign full_o    = valid_q;
  assign pop_o     = valid_q && m_ready_i;

endmodule

// File: rtl/ecp_rev_fsm.sv
module ecp_rev_fsm
  import ecp_rev_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic pclk_hi_i,
  input  logic buf_full_i,
  input  logic buf_pop_i,
  output logic capture_o,
  output logic host_ack_o,
  output logic timeout_err_o
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC - 1);

  rev_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             ack_q, err_q;
  logic             capture;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    unique case (state_q)
      ST_READY: begin
        if (!pclk_hi_i && !buf_full_i) begin
          state_d = ST_ACK;
          capture = 1'b1;
        end
      end
      ST_ACK: begin
        if (pclk_hi_i)           state_d = ST_DRAIN;
        else if (cnt_q == LIMIT) state_d = ST_FAULT;
      end
      ST_DRAIN: begin
        if (!buf_full_i || buf_pop_i) state_d = ST_READY;
      end
      ST_FAULT: state_d = ST_FAULT;
      default:  state_d = ST_READY;
    endcase
    if (!enable_i) begin
      state_d = ST_READY;
      capture = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READY;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_d != ST_READY);
      err_q   <= (state_d == ST_FAULT);
      if (state_q == ST_ACK && !pclk_hi_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      else                                                   cnt_q <= '0;
    end
  end

  assign capture_o     = capture;
  assign host_ack_o    = ack_q;
  assign timeout_err_o = err_q;

endmodule

// File: rtl/ecp_rev_host.sv
module ecp_rev_host #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              periph_clk_n_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              host_ack_o,
  output logic              timeout_err_o,
  output logic              m_valid_o,
  output logic [DATA_W-1:0] m_data_o,
  input  logic              m_ready_i
);

  logic pclk_hi_s;
  logic capture_s;
  logic full_s;
  logic pop_s;

  ecp_rev_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (periph_clk_n_i),
    .sync_o  (pclk_hi_s)
  );

  ecp_rev_outbuf #(.DATA_W(DATA_W)) u_obuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_i     (bus_data_i),
    .load_i    (capture_s),
    .m_ready_i (m_ready_i),
    .m_valid_o (m_valid_o),
    .m_data_o  (m_data_o),
    .full_o    (full_s),
    .pop_o     (pop_s)
  );

  ecp_rev_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable_i      (enable_i),
    .pclk_hi_i     (pclk_hi_s),
    .buf_full_i    (full_s),
    .buf_pop_i     (pop_s),
    .capture_o     (capture_s),
    .host_ack_o    (host_ack_o),
    .timeout_err_o (timeout_err_o)
  );

endmodule

// File: rtl/ecp_rev_host_chk.sv
module ecp_rev_host_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable_i,
  input logic              pclk_hi_s,
  input logic              host_ack_o,
  input logic              timeout_err_o,
  input logic              m_valid_o,
  input logic [DATA_W-1:0] m_data_o,
  input logic              m_ready_i
);

  // R2
  ack_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !host_ack_o);

  // R3
  ack_rise_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack_o) |-> $past(!pclk_hi_s));

  // R4
  capture_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack_o) |-> $rose(m_valid_o));

  // R5
  ack_hold_low_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_ack_o) && $past(enable_i) |-> $past(pclk_hi_s));

  // R6
  ack_fall_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_ack_o) && $past(enable_i) |-> $past(!m_valid_o || m_ready_i));

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o));

  // R9
  err_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err_o |-> host_ack_o);

endmodule

bind ecp_rev_host ecp_rev_host_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable_i      (enable_i),
  .pclk_hi_s     (pclk_hi_s),
  .host_ack_o    (host_ack_o),
  .timeout_err_o (timeout_err_o),
  .m_valid_o     (m_valid_o),
  .m_data_o      (m_data_o),
  .m_ready_i     (m_ready_i)
);

// File: tb/test_ecp_rev_host.sv
module test_ecp_rev_host;

  localparam int DW = 8;
  localparam int TO = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          pclk_n = 1'b1;
  logic [DW-1:0] bus = '0;
  logic          host_ack, terr, m_valid, m_ready = 1'b0;
  logic [DW-1:0] m_data;

  int errs = 0, checks = 0;
  int tx_n = 0, rx_n = 0;
  int ready_mode = 2;  // 0 random, 1 stall, 2 always ready
  logic [DW-1:0] exp_mem [0:511];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ecp_rev_host #(.DATA_W(DW), .SYNC_STAGES(2), .TIMEOUT_CYC(TO)) i_ecp_rev_host (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .periph_clk_n_i(pclk_n),
    .bus_data_i(bus), .host_ack_o(host_ack), .timeout_err_o(terr),
    .m_valid_o(m_valid), .m_data_o(m_data), .m_ready_i(m_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] pick_byte();
    return DW'($urandom);
  endfunction

  // Consumer: decides ready at each negedge, records bytes moved at next posedge
  always @(negedge clk) begin
    logic r;
    case (ready_mode)
      0:       r = ($urandom % 3) != 0;
      1:       r = 1'b0;
      default: r = 1'b1;
    endcase
    m_ready = r;
    if (rst_n && m_valid && r) begin
      // R4 R8: byte matches the one the peripheral presented, in order
      chk(rx_n < tx_n && m_data == exp_mem[rx_n[8:0]], "R4/R8 byte order", m_data, exp_mem[rx_n[8:0]]);
      rx_n++;
    end
  end

  task automatic wait_ack(input logic lvl);
    for (int n = 0; n < 400 && host_ack !== lvl; n++) @(negedge clk);
  endtask

  // Peripheral model: one reverse transfer
  task automatic send_byte(input logic [DW-1:0] d, input int pre, input int hold, input bit directed);
    wait_ack(1'b0);
    bus = d;
    repeat (pre) @(negedge clk);
    exp_mem[tx_n[8:0]] = d;
    tx_n++;
    pclk_n = 1'b0;
    if (directed) begin
      @(negedge clk); chk(host_ack == 1'b0, "R3 no ack 1 cycle after strobe", host_ack, 0);
      @(negedge clk); chk(host_ack == 1'b0, "R3 no ack 2 cycles after strobe", host_ack, 0);
      @(negedge clk); chk(host_ack == 1'b1, "R3 ack on third edge", host_ack, 1);
      chk(m_valid == 1'b1, "R4 valid with ack", m_valid, 1);
    end
    wait_ack(1'b1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (directed) chk(host_ack == 1'b1, "R5 ack held while strobe low", host_ack, 1);
    end
    pclk_n = 1'b1;
    bus = pick_byte();
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(host_ack == 1'b0, "R1 ack in reset", host_ack, 0);
    chk(m_valid == 1'b0, "R1 valid in reset", m_valid, 0);
    chk(terr == 1'b0, "R1 err in reset", terr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_ack == 1'b0 && m_valid == 1'b0 && terr == 1'b0, "R1 after reset", {host_ack, m_valid, terr}, 0);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    // R10: idle with strobe high and empty output
    chk(host_ack == 1'b0, "R10 idle ack low", host_ack, 0);

    // Directed latency and hold
    ready_mode = 2;
    send_byte(8'hA5, 1, 6, 1'b1);
    send_byte(8'h00, 0, 2, 1'b1);
    send_byte(8'hFF, 2, 3, 1'b1);

    // R6 R7: back-pressure keeps ack high and byte stable
    repeat (6) @(negedge clk);
    ready_mode = 1;
    send_byte(8'h3C, 1, 1, 1'b0);
    repeat (10) @(negedge clk);
    chk(host_ack == 1'b1, "R6 ack held while output full", host_ack, 1);
    chk(m_valid == 1'b1, "R7 valid held under stall", m_valid, 1);
    chk(m_data == 8'h3C, "R7 data stable under stall", m_data, 8'h3C);
    ready_mode = 2;
    for (int n = 0; n < 10 && m_valid; n++) @(negedge clk);
    chk(host_ack == 1'b0, "R6 ack falls with accept", host_ack, 0);
    repeat (5) @(negedge clk);
    chk(host_ack == 1'b0, "R10 ack rests low", host_ack, 0);

    // Random traffic with random stalls
    ready_mode = 0;
    for (int k = 0; k < 60; k++) begin
      send_byte(pick_byte(), $urandom % 4, $urandom % 5, 1'b0);
    end
    ready_mode = 2;
    for (int n = 0; n < 200 && rx_n != tx_n; n++) @(negedge clk);
    chk(rx_n == tx_n, "R8 all bytes delivered once", rx_n, tx_n);

    // R9: strobe stuck low
    begin
      int cyc;
      wait_ack(1'b0);
      bus = 8'h96;
      @(negedge clk);
      exp_mem[tx_n[8:0]] = 8'h96;
      tx_n++;
      pclk_n = 1'b0;
      wait_ack(1'b1);
      cyc = 0;
      for (int n = 0; n < 200 && !terr; n++) begin
        @(negedge clk);
        cyc++;
      end
      chk(cyc == TO, "R9 timeout cycle", cyc, TO);
      chk(host_ack == 1'b1, "R9 ack high in fault", host_ack, 1);
      enable = 1'b0;
      @(negedge clk);
      chk(terr == 1'b0, "R9 err cleared by disable", terr, 0);
      chk(host_ack == 1'b0, "R2 ack low after disable", host_ack, 0);
      pclk_n = 1'b1;
    end
    for (int n = 0; n < 20 && m_valid; n++) @(negedge clk);

    // R2: strobe ignored while disabled, taken once enabled
    bus = 8'h5A;
    @(negedge clk);
    exp_mem[tx_n[8:0]] = 8'h5A;
    tx_n++;
    pclk_n = 1'b0;
    begin
      bit stayed = 1'b1;
      for (int n = 0; n < 10; n++) begin
        @(negedge clk);
        if (host_ack || m_valid) stayed = 1'b0;
      end
      chk(stayed, "R2 no ack or capture while disabled", {host_ack, m_valid}, 0);
    end
    enable = 1'b1;
    @(negedge clk);
    chk(host_ack == 1'b1, "R2 ack after re-enable", host_ack, 1);
    @(negedge clk);
    pclk_n = 1'b1;
    for (int n = 0; n < 50 && (rx_n != tx_n || host_ack); n++) @(negedge clk);
    chk(rx_n == tx_n, "R8 final count", rx_n, tx_n);
    chk(host_ack == 1'b0, "R10 final idle", host_ack, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", tx_n, rx_n);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule